// File: doc/BRIEF.md
# Banked GPIO port register file

This block is the register side of a general-purpose I/O port with a parameterised number of pins, a multiple of 32. A host reaches it through a plain 32-bit register bus made of an address, a write strobe, write data and registered read data. Each 32-pin bank has a read-only level word fed by two-flop synchronised pin inputs, and a direction word whose bits drive the pin output enables. It also has a pair of write-one set and write-one clear words that change the output latches without a read-modify-write. A further group of words packs a two-bit alternate-function code for every pin, 16 pins to a word, and these codes are presented to the pad multiplexing logic outside the block.

Registers are laid out by kind. All banks of one kind sit next to each other, and then the next kind starts. The kind order is level, direction, set, clear, three reserved kinds, and last the alternate-function group. With `B = NUM_PINS/32` banks, the word for kind `k` and bank `b` lives at byte address `(k*B + b)*4`. The alternate-function group starts at word `7*B` and spans `2*B` words.

Top module: `gpio_port`

## Requirements
- R1: While and after reset, rdata_o, pin_out_o, pin_oe_o and alt_sel_o are all 0, so every pin is an input, every latch is low and every pin uses code 0 (plain GPIO).
- R2: The word for kind k of bank b is at byte address (k*B+b)*4 with B = NUM_PINS/32. The kinds are 0 level, 1 direction, 2 set, 3 clear and 7 alternate function. Kinds 4, 5 and 6 are reserved: they read 0 and writes to them change no output. Address bits [1:0] are ignored. Within a bank word, bit i belongs to pin 32*b+i.
- R3: A level word read returns pins_i of its bank after two synchronising flops. A change on pins_i in the cycle before edge n is first returned by a read whose address is presented in the cycle before edge n+2, and it appears on rdata_o after that edge. Writes to level words are ignored.
- R4: Writing a direction word loads it whole. A 1 drives the matching pin_oe_o bit high (output) and a 0 makes the pin an input. The word reads back as written.
- R5: Writing a set word raises each pin_out_o bit whose data bit is 1 and leaves the others unchanged. Set words read as 0.
- R6: Writing a clear word lowers each pin_out_o bit whose data bit is 1 and leaves the others unchanged. Clear words read as 0.
- R7: Alternate-function word w, at word address 7*B+w, holds pins 16w to 16w+15. The code of pin p sits at bits [2*(p mod 16)+1 : 2*(p mod 16)] and drives alt_sel_o[2p+1:2p]. The word reads back as written.
- R8: rdata_o is registered. It shows the value addressed in the previous cycle. A read that coincides with a write to the same word returns the value before the write.
- R9: Word addresses at or above 9*B read 0, and writes to them change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address of the accessed word |
| we_i | input | 1 | Write strobe for the current cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the address |
| pins_i | input | NUM_PINS | Pin input levels, asynchronous |
| pin_out_o | output | NUM_PINS | Output latch values |
| pin_oe_o | output | NUM_PINS | Output enables, 1 means output |
| alt_sel_o | output | 2*NUM_PINS | Two-bit alternate-function code per pin |

## Verification
The bench builds the port with NUM_PINS = 96, so there are three banks. A bank count that is not a power of two means the word-to-kind split cannot be done by bit slicing. This brings the kind boundaries (word 21 where the alternate-function group starts, word 27 where the map ends) and the top bank of each kind within reach of directed and random accesses. The random phase writes all kinds, the reserved ones and out-of-range words, with unaligned low address bits and changing pins. A behavioural model is compared against every output on each clock.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned WORD_W       = 32;
  localparam int unsigned ALT_CODE_W   = 2;
  localparam int unsigned ALT_PER_WORD = WORD_W / ALT_CODE_W;
  localparam int unsigned ALT_WPB      = WORD_W / ALT_PER_WORD;  // alt words per bank

  typedef enum logic [2:0] {
    KIND_LEVEL = 3'd0,
    KIND_DIR   = 3'd1,
    KIND_SET   = 3'd2,
    KIND_CLR   = 3'd3,
    KIND_RSV4  = 3'd4,
    KIND_RSV5  = 3'd5,
    KIND_RSV6  = 3'd6,
    KIND_ALT   = 3'd7
  } reg_kind_e;

  function automatic int unsigned word_of(reg_kind_e kind, int unsigned n_banks,
                                          int unsigned idx);
    return int'(kind) * n_banks + idx;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_port_pkg::*;
#(
  parameter int unsigned BANK    = 0,
  parameter int unsigned N_BANKS = 2,
  parameter int unsigned WA_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WA_W-1:0]   waddr_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] level_i,
  output logic [WORD_W-1:0] out_o,
  output logic [WORD_W-1:0] oe_o,
  output logic [WORD_W-1:0] rdata_o
);
  localparam logic [WA_W-1:0] A_LEVEL = WA_W'(word_of(KIND_LEVEL, N_BANKS, BANK));
  localparam logic [WA_W-1:0] A_DIR   = WA_W'(word_of(KIND_DIR,   N_BANKS, BANK));
  localparam logic [WA_W-1:0] A_SET   = WA_W'(word_of(KIND_SET,   N_BANKS, BANK));
  localparam logic [WA_W-1:0] A_CLR   = WA_W'(word_of(KIND_CLR,   N_BANKS, BANK));

  logic hit_level, hit_dir, hit_set, hit_clr;
  logic [WORD_W-1:0] dir_q, lat_q;

  assign hit_level = (waddr_i == A_LEVEL);
  assign hit_dir   = (waddr_i == A_DIR);
  assign hit_set   = (waddr_i == A_SET);
  assign hit_clr   = (waddr_i == A_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      lat_q <= '0;
    end else if (we_i) begin
      if (hit_dir) dir_q <= wdata_i;
      if (hit_set)      lat_q <= lat_q | wdata_i;
      else if (hit_clr) lat_q <= lat_q & ~wdata_i;
    end
  end

  // set and clear words read as zero; level writes fall through
  always_comb begin
    rdata_o = '0;
    if (hit_level)    rdata_o = level_i;
    else if (hit_dir) rdata_o = dir_q;
  end

  assign out_o = lat_q;
  assign oe_o  = dir_q;

  a_r4_oe_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i == A_DIR) |=> oe_o == $past(wdata_i));

  a_r4_oe_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && waddr_i == A_DIR) |=> $stable(oe_o));

  a_r5_set_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i == A_SET) |=>
      ((out_o & $past(wdata_i)) == $past(wdata_i)) &&
      ((out_o & ~$past(wdata_i)) == ($past(out_o) & ~$past(wdata_i))));

  a_r6_clr_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i == A_CLR) |=>
      ((out_o & $past(wdata_i)) == '0) &&
      ((out_o & ~$past(wdata_i)) == ($past(out_o) & ~$past(wdata_i))));

  a_r5_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (waddr_i == A_SET || waddr_i == A_CLR)) |=> $stable(out_o));
endmodule

// File: rtl/gpio_altfn.sv
module gpio_altfn
  import gpio_port_pkg::*;
#(
  parameter int unsigned N_WORDS = 4,
  parameter int unsigned BASE    = 14,
  parameter int unsigned WA_W    = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [WA_W-1:0]           waddr_i,
  input  logic                      we_i,
  input  logic [WORD_W-1:0]         wdata_i,
  output logic [N_WORDS*WORD_W-1:0] alt_o,
  output logic [WORD_W-1:0]         rdata_o
);
  logic [N_WORDS-1:0][WORD_W-1:0] alt_q;
  logic [N_WORDS-1:0]             hit;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    localparam logic [WA_W-1:0] A_WORD = WA_W'(BASE + w);
    assign hit[w] = (waddr_i == A_WORD);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              alt_q[w] <= '0;
      else if (we_i && hit[w])  alt_q[w] <= wdata_i;
    end

    a_r7_alt_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && waddr_i == A_WORD) |=> alt_o[w*WORD_W +: WORD_W] == $past(wdata_i));

    a_r7_alt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && waddr_i == A_WORD) |=> $stable(alt_o[w*WORD_W +: WORD_W]));
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < N_WORDS; w++) if (hit[w]) rdata_o = alt_q[w];
  end

  assign alt_o = alt_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 64,
  parameter int unsigned ADDR_W   = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    we_i,
  input  logic [WORD_W-1:0]       wdata_i,
  output logic [WORD_W-1:0]       rdata_o,
  input  logic [NUM_PINS-1:0]     pins_i,
  output logic [NUM_PINS-1:0]     pin_out_o,
  output logic [NUM_PINS-1:0]     pin_oe_o,
  output logic [2*NUM_PINS-1:0]   alt_sel_o
);
  localparam int unsigned N_BANKS     = NUM_PINS / WORD_W;
  localparam int unsigned WA_W        = ADDR_W - 2;
  localparam int unsigned N_ALT_WORDS = N_BANKS * ALT_WPB;
  localparam int unsigned ALT_BASE    = word_of(KIND_ALT, N_BANKS, 0);
  localparam int unsigned MAP_WORDS   = ALT_BASE + N_ALT_WORDS;
  localparam int unsigned RSV_LO      = word_of(KIND_RSV4, N_BANKS, 0);

  logic [WA_W-1:0]                 waddr;
  logic                            unused_lsb;
  logic [NUM_PINS-1:0]             level_s;
  logic [N_BANKS-1:0][WORD_W-1:0]  bank_rd;
  logic [WORD_W-1:0]               alt_rd, rd_mux;

  assign waddr      = addr_i[ADDR_W-1:2];
  assign unused_lsb = ^addr_i[1:0];

  gpio_sync #(.W(NUM_PINS)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_i),
    .q_o    (level_s)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    gpio_bank #(.BANK(b), .N_BANKS(N_BANKS), .WA_W(WA_W)) i_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .waddr_i (waddr),
      .we_i    (we_i),
      .wdata_i (wdata_i),
      .level_i (level_s[b*WORD_W +: WORD_W]),
      .out_o   (pin_out_o[b*WORD_W +: WORD_W]),
      .oe_o    (pin_oe_o[b*WORD_W +: WORD_W]),
      .rdata_o (bank_rd[b])
    );

    localparam logic [WA_W-1:0] A_SET = WA_W'(word_of(KIND_SET, N_BANKS, b));
    localparam logic [WA_W-1:0] A_CLR = WA_W'(word_of(KIND_CLR, N_BANKS, b));

    a_r5_set_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (waddr == A_SET) |=> rdata_o == '0);

    a_r6_clr_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (waddr == A_CLR) |=> rdata_o == '0);
  end

  gpio_altfn #(.N_WORDS(N_ALT_WORDS), .BASE(ALT_BASE), .WA_W(WA_W)) i_altfn (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .waddr_i (waddr),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .alt_o   (alt_sel_o),
    .rdata_o (alt_rd)
  );

  // at most one source is non-zero for any address
  always_comb begin
    rd_mux = alt_rd;
    for (int b = 0; b < N_BANKS; b++) rd_mux = rd_mux | bank_rd[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_mux;
  end

  a_r9_oob_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({{(32-WA_W){1'b0}}, waddr} >= MAP_WORDS) |=> rdata_o == '0);

  a_r2_rsv_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({{(32-WA_W){1'b0}}, waddr} >= RSV_LO && {{(32-WA_W){1'b0}}, waddr} < ALT_BASE)
      |=> rdata_o == '0);

  a_r9_oob_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({{(32-WA_W){1'b0}}, waddr} >= MAP_WORDS)
      |=> $stable(pin_out_o) && $stable(pin_oe_o) && $stable(alt_sel_o));
endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 96;
  localparam int NB = NP / 32;
  localparam int AW = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic            we = 1'b0;
  logic [31:0]     wd = '0;
  logic [31:0]     rdata;
  logic [NP-1:0]   pins = '0;
  logic [NP-1:0]   pin_out, pin_oe;
  logic [2*NP-1:0] alt_sel;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  gpio_port #(.NUM_PINS(NP), .ADDR_W(AW)) i_gpio_port (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .addr_i    (addr),
    .we_i      (we),
    .wdata_i   (wd),
    .rdata_o   (rdata),
    .pins_i    (pins),
    .pin_out_o (pin_out),
    .pin_oe_o  (pin_oe),
    .alt_sel_o (alt_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  logic [NP-1:0]   m_dir = '0, m_lat = '0, m_s1 = '0, m_s2 = '0;
  logic [2*NP-1:0] m_alt = '0;
  logic [31:0]     m_rd = '0;

  function automatic logic [31:0] model_read(int w);
    if (w < 7*NB) begin
      case (w / NB)
        0: return m_s2[(w%NB)*32 +: 32];
        1: return m_dir[(w%NB)*32 +: 32];
        default: return 32'h0;
      endcase
    end else if (w < 9*NB) return m_alt[(w-7*NB)*32 +: 32];
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = '0; m_lat = '0; m_s1 = '0; m_s2 = '0; m_alt = '0; m_rd = '0;
    end else begin
      int w;
      w = int'(addr[AW-1:2]);
      m_rd = model_read(w);
      if (we) begin
        if (w < 7*NB) begin
          case (w / NB)
            1: m_dir[(w%NB)*32 +: 32] = wd;
            2: m_lat[(w%NB)*32 +: 32] = m_lat[(w%NB)*32 +: 32] | wd;
            3: m_lat[(w%NB)*32 +: 32] = m_lat[(w%NB)*32 +: 32] & ~wd;
            default: ;
          endcase
        end else if (w < 9*NB) m_alt[(w-7*NB)*32 +: 32] = wd;
      end
      m_s2 = m_s1;
      m_s1 = pins;
    end
  end

  task automatic chk(input string tag, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    chk("R5 model pin_out", {96'h0, pin_out}, {96'h0, m_lat});
    chk("R4 model pin_oe",  {96'h0, pin_oe},  {96'h0, m_dir});
    chk("R7 model alt_sel", alt_sel, m_alt);
    chk("R8 model rdata",   {160'h0, rdata}, {160'h0, m_rd});
  end

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a; we = 1'b0;
    @(negedge clk); chk(tag, {160'h0, rdata}, {160'h0, exp});
  endtask

  task automatic finish_sim();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*50000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R8 watchdog expired: got 0 expected 1");
      finish_sim();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset rdata", {160'h0, rdata}, 192'h0);
    chk("R1 reset pin_out", {96'h0, pin_out}, 192'h0);
    chk("R1 reset pin_oe", {96'h0, pin_oe}, 192'h0);
    chk("R1 reset alt_sel", alt_sel, 192'h0);

    // level path
    pins = 96'hDEAD_BEEF_0123_4567_89AB_CDEF;
    repeat (3) @(negedge clk);
    bus_rd(10'd0, 32'h89AB_CDEF, "R3 level bank0");
    bus_rd(10'd8, 32'hDEAD_BEEF, "R3 level bank2");
    @(negedge clk); pins[63:32] = 32'h5555_AAAA; addr = 10'd4; we = 1'b0;
    @(negedge clk);
    @(negedge clk); chk("R3 sync still old", {160'h0, rdata}, {160'h0, 32'h0123_4567});
    @(negedge clk); chk("R3 sync new", {160'h0, rdata}, {160'h0, 32'h5555_AAAA});
    bus_wr(10'd4, 32'hFFFF_FFFF);
    bus_rd(10'd4, 32'h5555_AAAA, "R3 level write ignored");

    // direction
    bus_wr(10'd16, 32'hA5A5_0F0F);
    chk("R4 oe bank1", {96'h0, pin_oe}, {96'h0, 32'h0, 32'hA5A5_0F0F, 32'h0});
    bus_rd(10'd16, 32'hA5A5_0F0F, "R4 dir readback");
    bus_rd(10'd17, 32'hA5A5_0F0F, "R2 low address bits ignored");

    // set / clear
    bus_wr(10'd24, 32'h0000_00F0);
    chk("R5 set F0", {96'h0, pin_out}, {96'h0, 64'h0, 32'h0000_00F0});
    bus_wr(10'd24, 32'h0000_000F);
    chk("R5 set keeps zeros", {96'h0, pin_out}, {96'h0, 64'h0, 32'h0000_00FF});
    bus_rd(10'd24, 32'h0, "R5 set reads zero");
    bus_wr(10'd36, 32'h0000_0030);
    chk("R6 clear 30", {96'h0, pin_out}, {96'h0, 64'h0, 32'h0000_00CF});
    bus_rd(10'd36, 32'h0, "R6 clear reads zero");
    bus_wr(10'd32, 32'h8000_0001);
    chk("R5 set bank2", {96'h0, pin_out}, {96'h0, 32'h8000_0001, 32'h0, 32'h0000_00CF});
    bus_wr(10'd44, 32'h0000_0001);
    chk("R6 clear bank2", {96'h0, pin_out}, {96'h0, 32'h8000_0000, 32'h0, 32'h0000_00CF});

    // alternate function
    bus_wr(10'd84, 32'h0000_0006);
    chk("R7 pin0 code2 pin1 code1", alt_sel, 192'h6);
    bus_wr(10'd104, 32'hC000_0000);
    chk("R7 pin95 code3", {190'h0, alt_sel[191:190]}, 192'h3);
    bus_rd(10'd84, 32'h0000_0006, "R7 alt word0 readback");
    bus_rd(10'd104, 32'hC000_0000, "R7 alt word5 readback");

    // reserved kinds
    bus_wr(10'd48, 32'hFFFF_FFFF);
    bus_wr(10'd60, 32'hFFFF_FFFF);
    bus_wr(10'd80, 32'hFFFF_FFFF);
    bus_rd(10'd48, 32'h0, "R2 reserved kind4 reads zero");
    bus_rd(10'd80, 32'h0, "R2 reserved kind6 reads zero");
    chk("R2 reserved no effect out", {96'h0, pin_out}, {96'h0, 32'h8000_0000, 32'h0, 32'h0000_00CF});
    chk("R2 reserved no effect oe", {96'h0, pin_oe}, {96'h0, 32'h0, 32'hA5A5_0F0F, 32'h0});

    // out of range
    bus_wr(10'd108, 32'hFFFF_FFFF);
    bus_wr(10'd1020, 32'hFFFF_FFFF);
    bus_rd(10'd108, 32'h0, "R9 first oob word");
    bus_rd(10'd1020, 32'h0, "R9 top address");
    chk("R9 oob no effect alt", alt_sel, {2'b11, 186'h0, 4'h6});
    chk("R9 oob no effect oe", {96'h0, pin_oe}, {96'h0, 32'h0, 32'hA5A5_0F0F, 32'h0});

    // read during write, latency
    @(negedge clk); addr = 10'd12; we = 1'b1; wd = 32'h0000_FFFF;
    @(negedge clk); we = 1'b0;
    chk("R8 read during write old", {160'h0, rdata}, 192'h0);
    chk("R4 dir bank0", {96'h0, pin_oe}, {96'h0, 32'h0, 32'hA5A5_0F0F, 32'h0000_FFFF});
    @(negedge clk); chk("R8 next read new", {160'h0, rdata}, {160'h0, 32'h0000_FFFF});
    addr = 10'd16;
    @(negedge clk); chk("R8 one cycle latency", {160'h0, rdata}, {160'h0, 32'hA5A5_0F0F});

    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      addr = AW'((($urandom % 32) * 4) + ($urandom % 4));
      if (($urandom % 16) == 0) addr = AW'($urandom);
      we   = ($urandom % 2) == 1;
      wd   = $urandom;
      if (($urandom % 4) == 0) pins = {$urandom, $urandom, $urandom};
    end
    @(negedge clk); we = 1'b0;
    @(negedge clk);
    finish_sim();
  end
endmodule